// File: doc/BRIEF.md
# Four-Step Multiphase Switch Sequencer

This block produces the gate-enable pattern for the five power switches of a stepped switched-capacitor boost stage. A free-running ramp counter of `PERIOD` clocks forms the switching period. A duty word sets how long the charging phase (phase A) lasts, and a dead-time word sets the idle gaps around the transfer phase (phase B). The two phases never overlap. Duty and dead time are taken only when a new period begins. Both are clamped so that each phase keeps at least one active clock.

A two-bit step counter moves at the start of each phase A, except the first one after reset. It selects one of four steps in a fixed cyclic order. Phase A always drives the first switch alone. In phase B, the step decides which transfer switches close, so the four steps between them charge the pumping capacitors in series and then dump the stack into the output. With a 1 MHz clock and the default `PERIOD` of 20, the switching frequency is 50 kHz.

Top module: `msq_sequencer`

## Requirements
- R1: While `rst_n` is low, `sw_en`, `phase_a` and `phase_b` are all 0 and `step_idx` is 0.
- R2: The ramp repeats every `PERIOD` clocks, starting at count 0 in the first clock after reset release. `phase_a` is high for counts 0 through D-1, where D is the clamped duty.
- R3: `phase_b` is high for counts D+T through `PERIOD`-T-1, where T is the clamped dead time. Both phases are low in the T counts after `phase_a` falls and in the last T counts of the period. The two phases are never high together.
- R4: `duty_in` and `dead_in` are sampled only on the clock edge that starts a period. A change during a period has no effect on that period.
- R5: The duty is clamped to the range 1 through `PERIOD`-2T-1. For example, with `PERIOD`=20 and T=2, a duty of 0 becomes 1 and a duty of 19 becomes 15.
- R6: The dead time is clamped to the range 1 through `DEAD_MAX`. With `DEAD_MAX`=4, 0 becomes 1 and 7 becomes 4.
- R7: `step_idx` is 0 for the first period after reset. It then increases by 1 modulo 4 at the start of each later period, and it holds its value at all other times.
- R8: `sw_en[0]` equals `phase_a`. While `phase_a` is high, no other `sw_en` bit is set.
- R9: `sw_en[1]` is `phase_b` on steps 0 and 2. `sw_en[2]` is `phase_b` on steps 1 and 3.
- R10: `sw_en[3]` is `phase_b` on step 1 only. `sw_en[4]` is `phase_b` on step 3 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_in | input | CNT_W | Requested phase A length in clocks |
| dead_in | input | DEAD_W | Requested dead time in clocks |
| sw_en | output | 5 | Switch enables; bit k drives switch k+1 |
| phase_a | output | 1 | Charging phase |
| phase_b | output | 1 | Transfer phase |
| step_idx | output | 2 | Current step, 0 to 3 |

## Verification
The hardest situations to reach from the ports are a duty or dead time that changes partway through a period, and a step count restart caused by a second reset in mid-sequence. The stimulus reaches the first by driving a new duty and dead time three clocks into a period, while the expected values for that period stay tied to the old settings. It reaches the second by asserting reset after the step has left 0, then checking that the first period after release is step 0 again and that the following period is step 1. Out-of-range duty and dead-time values are driven at both extremes to exercise the clamps.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int NUM_SW = 5;
  localparam int SW_CHG = 0;   // phase A switch
  localparam int SW_EVN = 1;   // phase B, steps 0 and 2
  localparam int SW_ODD = 2;   // phase B, steps 1 and 3
  localparam int SW_ST1 = 3;   // phase B, step 1 only
  localparam int SW_ST3 = 4;   // phase B, step 3 only

  // Dead time limited to [1, dmax]
  function automatic int clamp_dead(int req, int dmax);
    if (req < 1) return 1;
    if (req > dmax) return dmax;
    return req;
  endfunction

  // Duty limited so both phases keep at least one active clock
  function automatic int clamp_duty(int req, int dead, int period);
    int hi;
    hi = period - 2 * dead - 1;
    if (req < 1) return 1;
    if (req > hi) return hi;
    return req;
  endfunction
endpackage

// File: rtl/msq_pwm_core.sv
module msq_pwm_core #(
  parameter int PERIOD   = 20,
  parameter int DEAD_MAX = 4,
  parameter int CNT_W    = 5,
  parameter int DEAD_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  duty_in,
  input  logic [DEAD_W-1:0] dead_in,
  output logic              period_wrap,
  output logic              phase_a,
  output logic              phase_b
);
  import msq_pkg::*;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0]  ramp;
  logic [CNT_W-1:0]  duty_q;
  logic [DEAD_W-1:0] dead_q;
  int                dead_nx;

  assign period_wrap = (ramp == LAST);
  assign dead_nx     = clamp_dead(int'(dead_in), DEAD_MAX);

  // Reset parks the ramp on its last count with zero duty, so both phases
  // stay low and the first edge after release opens a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp   <= LAST;
      duty_q <= '0;
      dead_q <= DEAD_W'(1);
    end else if (period_wrap) begin
      ramp   <= '0;
      dead_q <= DEAD_W'(dead_nx);
      duty_q <= CNT_W'(clamp_duty(int'(duty_in), dead_nx, PERIOD));
    end else begin
      ramp <= ramp + 1'b1;
    end
  end

  always_comb begin
    int r, d, t;
    r = int'(ramp);
    d = int'(duty_q);
    t = int'(dead_q);
    phase_a = (r < d);
    phase_b = (r >= d + t) && (r < PERIOD - t);
  end
endmodule

// File: rtl/msq_step_ctr.sv
module msq_step_ctr #(
  parameter int STEPS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] step_idx,
  output logic [STEPS-1:0] step_hot
);
  logic primed;

  // The first period start after reset only arms the counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_idx <= '0;
      primed   <= 1'b0;
    end else if (advance) begin
      if (primed) step_idx <= step_idx + 1'b1;
      primed <= 1'b1;
    end
  end

  for (genvar i = 0; i < STEPS; i++) begin : g_dec
    assign step_hot[i] = (step_idx == IDX_W'(i));
  end
endmodule

// File: rtl/msq_switch_map.sv
module msq_switch_map
  import msq_pkg::*;
(
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic [3:0]        step_hot,
  output logic [NUM_SW-1:0] sw_en
);
  always_comb begin
    sw_en         = '0;
    sw_en[SW_CHG] = phase_a;
    sw_en[SW_EVN] = phase_b & (step_hot[0] | step_hot[2]);
    sw_en[SW_ODD] = phase_b & (step_hot[1] | step_hot[3]);
    sw_en[SW_ST1] = phase_b & step_hot[1];
    sw_en[SW_ST3] = phase_b & step_hot[3];
  end
endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer #(
  parameter int PERIOD   = 20,
  parameter int DEAD_MAX = 4,
  parameter int CNT_W    = $clog2(PERIOD),
  parameter int DEAD_W   = $clog2(DEAD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  duty_in,
  input  logic [DEAD_W-1:0] dead_in,
  output logic [4:0]        sw_en,
  output logic              phase_a,
  output logic              phase_b,
  output logic [1:0]        step_idx
);
  logic       period_wrap;
  logic [3:0] step_hot;

  msq_pwm_core #(
    .PERIOD(PERIOD), .DEAD_MAX(DEAD_MAX), .CNT_W(CNT_W), .DEAD_W(DEAD_W)
  ) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .dead_in(dead_in),
    .period_wrap(period_wrap), .phase_a(phase_a), .phase_b(phase_b)
  );

  msq_step_ctr #(.STEPS(4), .IDX_W(2)) u_step (
    .clk(clk), .rst_n(rst_n), .advance(period_wrap),
    .step_idx(step_idx), .step_hot(step_hot)
  );

  msq_switch_map u_map (
    .phase_a(phase_a), .phase_b(phase_b), .step_hot(step_hot), .sw_en(sw_en)
  );
endmodule

// File: rtl/msq_checker.sv
module msq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_a,
  input logic       phase_b,
  input logic       period_wrap,
  input logic [1:0] step_idx,
  input logic [4:0] sw_en
);
  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_a && phase_b));
  p_dead_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_a) |-> !phase_b);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_a && !phase_b) |-> (sw_en == 5'b0));
  p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(step_idx));
  p_step_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != $past(step_idx)) |-> (step_idx == $past(step_idx) + 2'd1));
  p_chg_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_a |-> (sw_en == 5'b00001));
  p_xfer_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_b |-> ($countones(sw_en) == (step_idx[0] ? 2 : 1)) && !sw_en[0]);
  p_st1_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en[3] |-> (step_idx == 2'd1));
  p_st3_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en[4] |-> (step_idx == 2'd3));
endmodule

bind msq_sequencer msq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
  .period_wrap(period_wrap), .step_idx(step_idx), .sw_en(sw_en)
);

// File: tb/sim_msq_sequencer.sv
module sim_msq_sequencer;
  localparam int CLK_P = 10;
  localparam int P     = 20;
  localparam int DMAX  = 4;
  localparam int LIMIT = 5000;

  typedef struct packed {
    logic       a;
    logic       b;
    logic [1:0] st;
    logic [4:0] sw;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] duty_in = '0;
  logic [2:0] dead_in = '0;
  logic [4:0] sw_en;
  logic       phase_a, phase_b;
  logic [1:0] step_idx;

  item_t exp_q[$];
  string tag_q[$];
  int    errors = 0;
  int    checks = 0;
  int    m_step = 0;
  bit    m_first = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  msq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .dead_in(dead_in),
    .sw_en(sw_en), .phase_a(phase_a), .phase_b(phase_b), .step_idx(step_idx)
  );

  task automatic chk(string tag, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, expv, $time);
    end
  endtask

  // Driver: called at a negedge just before a period starts.
  task automatic push_period(int duty, int dead, string tag);
    int dd, hi, dc;
    dd = (dead < 1) ? 1 : ((dead > DMAX) ? DMAX : dead);
    hi = P - 1 - 2 * dd;
    dc = (duty < 1) ? 1 : ((duty > hi) ? hi : duty);
    if (m_first) m_first = 1'b0;
    else m_step = (m_step + 1) % 4;
    for (int c = 0; c < P; c++) begin
      item_t it;
      it.a  = (c < dc);
      it.b  = (c >= dc + dd) && (c <= P - 1 - dd);
      it.st = 2'(m_step);
      it.sw = {it.b && m_step == 3, it.b && m_step == 1,
               it.b && m_step[0], it.b && !m_step[0], it.a};
      exp_q.push_back(it);
      tag_q.push_back(tag);
    end
  endtask

  task automatic run_period(int duty, int dead, string tag);
    duty_in = 5'(duty);
    dead_in = 3'(dead);
    push_period(duty, dead, tag);
    repeat (P) @(negedge clk);
  endtask

  // Inputs change three clocks into the period; expectation keeps old values.
  task automatic run_period_mid(int duty, int dead, int nduty, int ndead);
    duty_in = 5'(duty);
    dead_in = 3'(dead);
    push_period(duty, dead, "R4");
    repeat (3) @(negedge clk);
    duty_in = 5'(nduty);
    dead_in = 3'(ndead);
    repeat (P - 3) @(negedge clk);
  endtask

  // Monitor: scoreboard pop a quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({"R2 phase_a ", t}, int'(phase_a), int'(e.a));
      chk({"R3 phase_b ", t}, int'(phase_b), int'(e.b));
      chk({"R7 step ", t}, int'(step_idx), int'(e.st));
      chk({"R8 sw0 ", t}, int'(sw_en[0]), int'(e.sw[0]));
      chk({"R9 sw1-2 ", t}, int'(sw_en[2:1]), int'(e.sw[2:1]));
      chk({"R10 sw3-4 ", t}, int'(sw_en[4:3]), int'(e.sw[4:3]));
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got=running expected=done");
    summary();
    $finish;
  end

  initial begin
    duty_in = 5'd6;
    dead_in = 3'd2;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    chk("R1 sw_en in reset", int'(sw_en), 0);
    chk("R1 phases in reset", int'({phase_a, phase_b}), 0);
    chk("R1 step in reset", int'(step_idx), 0);
    rst_n = 1'b1;
    // R2 R3 R7 R8 R9 R10: nominal, five periods wrap the step 0,1,2,3,0
    for (int k = 0; k < 5; k++) run_period(6, 2, "nominal");
    // R5: duty clamps
    run_period(0, 1, "R5 low");
    run_period(19, 2, "R5 high");
    run_period(31, 1, "R5 max word");
    // R6: dead-time clamps
    run_period(10, 0, "R6 zero");
    run_period(10, 7, "R6 over");
    // R4: mid-period change ignored, applied next period
    run_period_mid(5, 3, 12, 1);
    run_period(12, 1, "R4 next");
    // R1 and R7: second reset mid-sequence restarts at step 0
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sw_en re-reset", int'(sw_en), 0);
    chk("R1 step re-reset", int'(step_idx), 0);
    rst_n = 1'b1;
    m_first = 1'b1;
    m_step = 0;
    run_period(8, 3, "R7 restart");
    run_period(8, 3, "R7 after restart");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule